// File: doc/BRIEF.md
# Write-Protect Status Register Controller

This block owns the 8-bit status register of a serial NOR flash and decides whether each decoded write-class command may run. The SPI front end hands it one-cycle command strobes, already checked for byte alignment. These strobes are write enable, write disable, status write with its data byte, page program, sector erase, block erase and chip erase. Program and erase strobes come with a target byte address.

The controller keeps a write-enable latch and a one-time lock bit. It also decodes a three-bit protection level into a span of 64 KB blocks, protected from the top of memory downwards. A command that passes every check produces a one-cycle grant pulse with an operation code for the array sequencer. The grant also starts a self-timed busy interval, and each operation type has its own length in clock cycles. While that interval runs, the busy bit is set and every further command strobe is dropped. When the interval ends, the enable latch clears and a pending status write takes effect.

Top module: `wp_status_ctrl`

## Requirements
- R1: `status_o` bit 7 is the lock bit, bits 4..2 hold the protection level, bit 1 is the write-enable latch and bit 0 is busy. Bits 6..5 always read 0, and the whole register reads 00h after reset.
- R2: A write-enable strobe sets bit 1 and a write-disable strobe clears it, both visible one cycle later. While busy is 1, both strobes are ignored.
- R3: Status write, program and erase strobes are accepted only when the enable latch is 1 and busy is 0. A refused strobe gives no grant and leaves the enable latch unchanged.
- R4: Block index is `addr_i[18:16]`. Level 0 protects no block, level 1 protects block 7, level 2 protects blocks 6..7, level 3 protects blocks 4..7, and levels 4..7 protect every block.
- R5: Program, sector erase and block erase aimed at a protected block are refused. Chip erase is refused whenever the level is non-zero.
- R6: An accepted status write loads bit 7 and bits 4..2 from data bits 7 and 4..2 when its busy interval ends, and leaves bits 6, 5, 1 and 0 to their own logic. Once the lock bit is 1, status writes are refused, and only reset clears the lock.
- R7: For an accepted command, `grant_o` is high for exactly the one cycle after the strobe edge. `grant_op_o` is 1 for status write, 2 for program, 3 for sector erase, 4 for block erase and 5 for chip erase, and 0 otherwise.
- R8: Busy goes high together with the grant and stays high for exactly the operation's parameterized cycle count. Strobes arriving during that interval are dropped, and the enable latch clears when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| wrsr_i | input | 1 | Status-write strobe |
| wrsr_data_i | input | 8 | Status-write data byte |
| prog_i | input | 1 | Page-program strobe |
| sec_erase_i | input | 1 | Sector-erase strobe |
| blk_erase_i | input | 1 | Block-erase strobe |
| chip_erase_i | input | 1 | Chip-erase strobe |
| addr_i | input | ADDR_W | Target byte address for program and erase |
| status_o | output | 8 | Status register value |
| grant_o | output | 1 | One-cycle execute grant |
| grant_op_o | output | 3 | Code of the granted operation |

## Verification
Every result is due one register stage after the strobe edge. That covers the enable latch, the grant pulse, its code and the rise of busy. Busy then falls exactly N cycles after it rose, where N is that operation's count. A status write changes the lock and level bits only in the cycle busy falls.

The bench drives each strobe for one cycle from a falling edge and reads the grant and status on the next falling edge. It counts falling edges while busy is high and compares the count against the configured length. Commands dropped during busy are checked by seeing that no grant appears and that the enable latch and the busy end time stay as they were.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_WRSR   = 3'd1,
    OP_PROG   = 3'd2,
    OP_SERASE = 3'd3,
    OP_BERASE = 3'd4,
    OP_CERASE = 3'd5
  } wp_op_e;
endpackage

// File: rtl/wp_prot_decode.sv
module wp_prot_decode #(
  parameter int BLK_IDX_W = 3
) (
  input  logic [2:0]           level_i,
  input  logic [BLK_IDX_W-1:0] blk_i,
  output logic                 prot_o
);
  localparam int NUM_BLK = 1 << BLK_IDX_W;
  localparam int CW      = BLK_IDX_W + 1;

  logic [CW-1:0] nprot;

  // number of top blocks covered by the level, clamped to the array size
  always_comb begin
    unique case (level_i)
      3'd0:    nprot = '0;
      3'd1:    nprot = CW'(1);
      3'd2:    nprot = CW'(2);
      3'd3:    nprot = CW'(4);
      default: nprot = CW'(NUM_BLK);
    endcase
    if (nprot > CW'(NUM_BLK)) nprot = CW'(NUM_BLK);
  end

  assign prot_o = ({1'b0, blk_i} + nprot) >= CW'(NUM_BLK);
endmodule

// File: rtl/wp_busy_timer.sv
module wp_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q <= CNT_W'(1)) busy_q <= 1'b0;
      else                    cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BLK_W  = 16,
  parameter int T_WRSR = 200,
  parameter int T_PP   = 100,
  parameter int T_SE   = 400,
  parameter int T_BE   = 800,
  parameter int T_CE   = 1600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              prog_i,
  input  logic              sec_erase_i,
  input  logic              blk_erase_i,
  input  logic              chip_erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic [2:0]        grant_op_o
);
  localparam int BLK_IDX_W = ADDR_W - BLK_W;
  localparam int MAX_A = (T_WRSR > T_PP) ? T_WRSR : T_PP;
  localparam int MAX_B = (T_SE > T_BE) ? T_SE : T_BE;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T = (MAX_C > T_CE) ? MAX_C : T_CE;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic       srwd_q, wel_q, pend_vld_q, grant_q;
  logic [2:0] bp_q;
  logic [3:0] pend_q;
  wp_op_e     grant_op_q, sel_op;
  logic       ok, accept, prot, busy, done;
  logic [CNT_W-1:0] load_val;

  logic unused_in;
  assign unused_in = ^{addr_i[BLK_W-1:0], wrsr_data_i[6:5], wrsr_data_i[1:0]};

  wp_prot_decode #(.BLK_IDX_W(BLK_IDX_W)) u_decode (
    .level_i (bp_q),
    .blk_i   (addr_i[ADDR_W-1:BLK_W]),
    .prot_o  (prot)
  );

  wp_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .load_i  (load_val),
    .busy_o  (busy),
    .done_o  (done)
  );

  // strobes are expected one-hot; the order below only settles overlap
  always_comb begin
    if (chip_erase_i)     sel_op = OP_CERASE;
    else if (blk_erase_i) sel_op = OP_BERASE;
    else if (sec_erase_i) sel_op = OP_SERASE;
    else if (prog_i)      sel_op = OP_PROG;
    else if (wrsr_i)      sel_op = OP_WRSR;
    else                  sel_op = OP_NONE;

    unique case (sel_op)
      OP_WRSR:                     ok = !srwd_q;
      OP_PROG, OP_SERASE, OP_BERASE: ok = !prot;
      OP_CERASE:                   ok = (bp_q == 3'd0);
      default:                     ok = 1'b0;
    endcase

    unique case (sel_op)
      OP_WRSR:   load_val = CNT_W'(T_WRSR);
      OP_PROG:   load_val = CNT_W'(T_PP);
      OP_SERASE: load_val = CNT_W'(T_SE);
      OP_BERASE: load_val = CNT_W'(T_BE);
      OP_CERASE: load_val = CNT_W'(T_CE);
      default:   load_val = '0;
    endcase

    accept = (sel_op != OP_NONE) && wel_q && !busy && ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srwd_q     <= 1'b0;
      bp_q       <= 3'd0;
      wel_q      <= 1'b0;
      pend_q     <= 4'd0;
      pend_vld_q <= 1'b0;
      grant_q    <= 1'b0;
      grant_op_q <= OP_NONE;
    end else begin
      grant_q    <= accept;
      grant_op_q <= accept ? sel_op : OP_NONE;
      if (done) begin
        wel_q <= 1'b0;
        if (pend_vld_q) begin
          srwd_q     <= pend_q[3];
          bp_q       <= pend_q[2:0];
          pend_vld_q <= 1'b0;
        end
      end else if (!busy && !accept) begin
        if (wren_i)      wel_q <= 1'b1;
        else if (wrdi_i) wel_q <= 1'b0;
      end
      if (accept && sel_op == OP_WRSR) begin
        pend_q     <= {wrsr_data_i[7], wrsr_data_i[4:2]};
        pend_vld_q <= 1'b1;
      end
    end
  end

  assign status_o   = {srwd_q, 2'b00, bp_q, wel_q, busy};
  assign grant_o    = grant_q;
  assign grant_op_o = grant_op_q;
endmodule

// File: rtl/wp_status_ctrl_chk.sv
module wp_status_ctrl_chk
  import wp_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] status_o,
  input logic       grant_o,
  input logic [2:0] grant_op_o
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:5] == 2'b00);

  // R3
  grant_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> ($past(status_o[1]) && !$past(status_o[0])));

  // R8
  grant_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> status_o[0]);

  // R8
  wel_clear_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[0]) |-> !status_o[1]);

  // R6
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_o[7]) |-> status_o[7]);

  // R7
  grant_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);

  // R7
  grant_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o == (grant_op_o != 3'd0));

  // R5
  chip_erase_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && grant_op_o == OP_CERASE) |-> ($past(status_o[4:2]) == 3'd0));
endmodule

bind wp_status_ctrl wp_status_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .status_o   (status_o),
  .grant_o    (grant_o),
  .grant_op_o (grant_op_o)
);

// File: tb/tb_wp_status_ctrl.sv
module tb_wp_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_WRSR = 5;
  localparam int T_PP   = 3;
  localparam int T_SE   = 4;
  localparam int T_BE   = 6;
  localparam int T_CE   = 7;

  localparam int C_WREN = 0, C_WRDI = 1, C_WRSR = 2, C_PROG = 3,
                 C_SE = 4, C_BE = 5, C_CE = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wren_i = 0, wrdi_i = 0, wrsr_i = 0, prog_i = 0;
  logic        sec_erase_i = 0, blk_erase_i = 0, chip_erase_i = 0;
  logic [7:0]  wrsr_data_i = '0;
  logic [18:0] addr_i = '0;
  logic [7:0]  status_o;
  logic        grant_o;
  logic [2:0]  grant_op_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_status_ctrl #(
    .ADDR_W(19), .BLK_W(16),
    .T_WRSR(T_WRSR), .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE), .T_CE(T_CE)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_i(wrsr_i), .wrsr_data_i(wrsr_data_i),
    .prog_i(prog_i), .sec_erase_i(sec_erase_i), .blk_erase_i(blk_erase_i),
    .chip_erase_i(chip_erase_i), .addr_i(addr_i),
    .status_o(status_o), .grant_o(grant_o), .grant_op_o(grant_op_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one strobe for one cycle from a falling edge
  task automatic issue(input int cmd, input logic [7:0] d, input logic [18:0] a);
    wrsr_data_i = d;
    addr_i      = a;
    wren_i       = (cmd == C_WREN);
    wrdi_i       = (cmd == C_WRDI);
    wrsr_i       = (cmd == C_WRSR);
    prog_i       = (cmd == C_PROG);
    sec_erase_i  = (cmd == C_SE);
    blk_erase_i  = (cmd == C_BE);
    chip_erase_i = (cmd == C_CE);
    @(negedge clk);
    {wren_i, wrdi_i, wrsr_i, prog_i, sec_erase_i, blk_erase_i, chip_erase_i} = '0;
  endtask

  // count busy cycles, one already seen at the grant
  task automatic wait_idle(output int n);
    n = 1;
    while (status_o[0]) begin
      @(negedge clk);
      if (status_o[0]) n++;
    end
  endtask

  task automatic set_level(input logic [7:0] d, input logic [7:0] exp_status);
    int n;
    issue(C_WREN, 0, 0);
    issue(C_WRSR, d, 0);
    chk("R7 status write grant", {grant_o, grant_op_o}, {1'b1, 3'd1});
    chk("R6 level not yet applied while busy", status_o[0], 1);
    wait_idle(n);
    chk("R8 status write busy length", n, T_WRSR);
    chk("R6 status after write", status_o, exp_status);
  endtask

  task automatic t_reset();
    chk("R1 reset status", status_o, 8'h00);
    chk("R7 reset grant", grant_o, 0);
  endtask

  task automatic t_wel();
    issue(C_WREN, 0, 0);
    chk("R2 wren sets latch", status_o, 8'h02);
    issue(C_WRDI, 0, 0);
    chk("R2 wrdi clears latch", status_o, 8'h00);
  endtask

  task automatic t_no_wel();
    issue(C_PROG, 0, 19'h00010);
    chk("R3 program refused without latch", grant_o, 0);
    chk("R3 status unchanged", status_o, 8'h00);
  endtask

  task automatic t_prog_timing();
    issue(C_WREN, 0, 0);
    issue(C_PROG, 0, 19'h00010);
    chk("R7 program grant", {grant_o, grant_op_o}, {1'b1, 3'd2});
    chk("R8 busy with latch", status_o, 8'h03);
    for (int k = 1; k < T_PP; k++) begin
      @(negedge clk);
      chk("R8 busy held", status_o[0], 1);
      chk("R7 grant one cycle", grant_o, 0);
    end
    @(negedge clk);
    chk("R8 busy ends, latch cleared", status_o, 8'h00);
  endtask

  task automatic t_busy_ignore();
    issue(C_WREN, 0, 0);
    issue(C_SE, 0, 19'h01000);
    chk("R7 sector erase grant", {grant_o, grant_op_o}, {1'b1, 3'd3});
    issue(C_PROG, 0, 19'h00000);
    chk("R8 strobe during busy dropped", grant_o, 0);
    issue(C_WRDI, 0, 0);
    chk("R2 wrdi ignored while busy", status_o, 8'h03);
    @(negedge clk);
    chk("R8 last busy cycle", status_o, 8'h03);
    @(negedge clk);
    chk("R8 busy ends on original schedule", status_o, 8'h00);
  endtask

  task automatic t_level1();
    int n;
    set_level(8'h67, 8'h04);
    issue(C_WREN, 0, 0);
    issue(C_PROG, 0, 19'h70000);
    chk("R5 program block 7 refused at level 1", grant_o, 0);
    chk("R3 refused keeps latch", status_o, 8'h06);
    issue(C_PROG, 0, 19'h6FFFF);
    chk("R4 block 6 open at level 1", {grant_o, grant_op_o}, {1'b1, 3'd2});
    wait_idle(n);
    issue(C_WREN, 0, 0);
    issue(C_CE, 0, 0);
    chk("R5 chip erase refused at non-zero level", grant_o, 0);
    chk("R5 latch kept", status_o, 8'h06);
    issue(C_WRDI, 0, 0);
  endtask

  task automatic t_level3_2_4();
    int n;
    set_level(8'h0C, 8'h0C);
    issue(C_WREN, 0, 0);
    issue(C_SE, 0, 19'h40000);
    chk("R4 block 4 protected at level 3", grant_o, 0);
    issue(C_BE, 0, 19'h3FFFF);
    chk("R4 block 3 open at level 3", {grant_o, grant_op_o}, {1'b1, 3'd4});
    wait_idle(n);
    chk("R8 block erase busy length", n, T_BE);
    set_level(8'h08, 8'h08);
    issue(C_WREN, 0, 0);
    issue(C_PROG, 0, 19'h60000);
    chk("R4 block 6 protected at level 2", grant_o, 0);
    issue(C_PROG, 0, 19'h50000);
    chk("R4 block 5 open at level 2", grant_o, 1);
    wait_idle(n);
    set_level(8'h10, 8'h10);
    issue(C_WREN, 0, 0);
    issue(C_PROG, 0, 19'h00000);
    chk("R4 block 0 protected at level 4", grant_o, 0);
    issue(C_WRDI, 0, 0);
    chk("R2 latch cleared", status_o, 8'h10);
  endtask

  task automatic t_chip_erase();
    int n;
    set_level(8'h00, 8'h00);
    issue(C_WREN, 0, 0);
    issue(C_CE, 0, 0);
    chk("R7 chip erase grant", {grant_o, grant_op_o}, {1'b1, 3'd5});
    wait_idle(n);
    chk("R8 chip erase busy length", n, T_CE);
    chk("R8 latch cleared after chip erase", status_o, 8'h00);
  endtask

  task automatic t_lock();
    set_level(8'h9C, 8'h9C);
    issue(C_WREN, 0, 0);
    chk("R2 latch set under lock", status_o, 8'h9E);
    issue(C_WRSR, 8'h00, 0);
    chk("R6 status write refused when locked", grant_o, 0);
    @(negedge clk);
    chk("R6 locked bits unchanged", status_o, 8'h9E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_wel();
    t_no_wel();
    t_prog_timing();
    t_busy_ignore();
    t_level1();
    t_level3_2_4();
    t_chip_erase();
    t_lock();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule